// File: doc/BRIEF.md
# Multi-Port Storage Host Register Block

This block is the memory-mapped register file of a multi-port serial storage host adapter. A simple 32-bit address/data bus reads and writes a small set of global host registers at the bottom of the address space and one 128-byte register window per port above them. Per-port state covers the interrupt status and enable mask, the command/status control word, the task-file status readback, link status, the serial control word whose link-reset field can reset the port, and the command-issue vector.

The block also folds the per-port pending interrupts into a sticky global summary and drives one interrupt line. The command-processing engine sits beside it. That engine supplies per-port interrupt events, task-file bytes, device-presence flags and command-issue clears. In return it receives the command-issue vectors and a one-cycle reset pulse per port. Memory mastering and frame handling belong to the engine.

Top module: `hba_regs`

## Requirements
- R1: Only word-aligned accesses (addr[1:0] = 0) are decoded. Global registers occupy 0x000–0x0FF. Port i owns 0x100 + 128·i up to 0x100 + 128·(i+1) − 1, so the port index is (addr − 0x100) >> 7. Unaligned addresses, unused offsets and addresses beyond the last port window ignore writes and read as zero.
- R2: A read issued with rd_en returns its data on rdata after the next rising edge. A write takes effect at the edge on which wr_en is sampled.
- R3: Port interrupt status (offset 0x10) ORs in the port's event bits each cycle. A write clears the bits written as one. An event bit and a clear of the same bit in the same cycle leave the bit set.
- R4: Port interrupt mask (offset 0x14) stores the written value ANDed with 0xFDC000FF.
- R5: Port command word (offset 0x18) resets to 0x00000006. A write discards bits 15 and 14 of the value, then sets bit 15 if bit 0 (start) is set and bit 14 if bit 4 (receive enable) is set.
- R6: Task-file readback (offset 0x20) returns {16'b0, error byte, status byte} from the engine inputs. Writes to it have no effect.
- R7: Link status (offset 0x28) reads 0x00000113 when the port's device-present input is high, and 0 otherwise.
- R8: Writing serial control (offset 0x2C) with bits 3:0 = 0 while they hold 1 raises port_rst for that port for exactly one cycle after the write edge. The same edge clears that port's interrupt status and command-issue vector. Other transitions raise no pulse.
- R9: Command issue (offset 0x38) ORs written bits into its value. Engine clear bits remove slots. A written bit wins over a clear in the same cycle. The vector drives cmd_issue.
- R10: Global interrupt status (0x008) sets bit i one edge after port i has a bit set in both status and mask. It is write-one-to-clear and remains set while the port is still pending. irq is high while that register is nonzero and global control bit 1 is set.
- R11: Global control (0x004) resets to 0x80000000. A write stores bits 1:0 of the value with bit 31 forced on. A write with bit 0 set instead performs a controller reset: every register returns to its reset value and port_rst pulses for all ports.
- R12: Capabilities (0x000) read (ports−1) in bits 4:0, (slots−1) in bits 12:8 and bit 30 set. Ports-implemented (0x00C) reads (1<<ports)−1. Version (0x010) reads 0x00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one edge after rd_en |
| port_evt | input | NPORTS*32 | Per-port interrupt event bits |
| ci_clr | input | NPORTS*NSLOTS | Per-port command-issue clear bits from the engine |
| tf_err | input | NPORTS*8 | Per-port task-file error byte |
| tf_sts | input | NPORTS*8 | Per-port task-file status byte |
| dev_present | input | NPORTS | Per-port device attached flag |
| cmd_issue | output | NPORTS*NSLOTS | Per-port command-issue vectors |
| port_rst | output | NPORTS | One-cycle port reset pulses |
| irq | output | 1 | Interrupt output |

## Verification
Register writes land on the edge that samples wr_en. A read strobed in the following cycle therefore sees the new value, and its data sits on rdata after the next edge. The bench samples rdata on the falling edge after that. An event pulse reaches the port status after one edge, and the global summary and irq after a second edge. The checks on irq wait two falling edges after the pulse is driven. port_rst is high during the half-cycle after the write edge, so the bench samples it at the falling edge right after the write. It samples once more at the following falling edge to confirm the pulse lasts a single cycle.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;

  // global register offsets (low byte of address)
  localparam logic [7:0] G_CAP  = 8'h00;
  localparam logic [7:0] G_CTL  = 8'h04;
  localparam logic [7:0] G_IST  = 8'h08;
  localparam logic [7:0] G_IMPL = 8'h0C;
  localparam logic [7:0] G_VER  = 8'h10;

  // per-port register offsets inside a 128-byte window
  localparam logic [6:0] P_IST  = 7'h10;
  localparam logic [6:0] P_IEN  = 7'h14;
  localparam logic [6:0] P_CMD  = 7'h18;
  localparam logic [6:0] P_TF   = 7'h20;
  localparam logic [6:0] P_LINK = 7'h28;
  localparam logic [6:0] P_SCTL = 7'h2C;
  localparam logic [6:0] P_CI   = 7'h38;

  localparam int unsigned PORT_BASE  = 256;
  localparam int unsigned WIN_SHIFT  = 7;
  localparam logic [31:0] IEN_KEEP   = 32'hFDC0_00FF;
  localparam logic [31:0] CMD_RST    = 32'h0000_0006;
  localparam logic [31:0] CTL_RST    = 32'h8000_0000;
  localparam logic [31:0] VER_WORD   = 32'h0001_0000;
  localparam logic [31:0] LINK_UP    = 32'h0000_0113;

  function automatic logic [31:0] ien_filter(input logic [31:0] d);
    return d & IEN_KEEP;
  endfunction

  function automatic logic [31:0] cmd_filter(input logic [31:0] d);
    logic [31:0] r;
    r = d & ~32'h0000_C000;
    r[15] = d[0];
    r[14] = d[4];
    return r;
  endfunction

  function automatic logic [31:0] ctl_filter(input logic [1:0] d);
    return {1'b1, 29'd0, d};
  endfunction

  function automatic logic [31:0] tf_word(input logic [7:0] err, input logic [7:0] sts);
    return {16'd0, err, sts};
  endfunction

  function automatic logic [31:0] link_word(input logic present);
    return present ? LINK_UP : 32'd0;
  endfunction

  function automatic logic [31:0] cap_word(input int np, input int ns);
    logic [31:0] r;
    r = '0;
    r[4:0]  = 5'(np - 1);
    r[12:8] = 5'(ns - 1);
    r[30]   = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] impl_word(input int np);
    logic [32:0] one;
    one = 33'd1 << np;
    return 32'(one - 33'd1);
  endfunction

endpackage

// File: rtl/hba_regs_decode.sv
module hba_regs_decode #(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              glb_hit,
  output logic              port_hit,
  output logic [NPORTS-1:0] port_sel
);
  import hba_regs_pkg::*;

  localparam int unsigned PORT_END = PORT_BASE + (NPORTS << WIN_SHIFT);

  logic [31:0] a32;
  logic [31:0] rel;
  logic        aligned;

  assign a32     = 32'(addr);
  assign rel     = a32 - 32'(PORT_BASE);
  assign aligned = (addr[1:0] == 2'b00);
  assign glb_hit  = aligned && (a32 < 32'(PORT_BASE));
  assign port_hit = aligned && (a32 >= 32'(PORT_BASE)) && (a32 < 32'(PORT_END));

  for (genvar i = 0; i < NPORTS; i++) begin : g_sel
    assign port_sel[i] = port_hit && (rel[31:WIN_SHIFT] == (32-WIN_SHIFT)'(i));
  end
endmodule

// File: rtl/hba_regs_global.sv
module hba_regs_global #(
  parameter int NPORTS = 4,
  parameter int NSLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        off,
  input  logic [31:0]       wdata,
  input  logic [NPORTS-1:0] pend,
  output logic              hrst_req,
  output logic [31:0]       ctl_q,
  output logic [NPORTS-1:0] gist_q,
  output logic              irq,
  output logic [31:0]       rword
);
  import hba_regs_pkg::*;

  logic wr_ctl, wr_ist;
  logic [NPORTS-1:0] clr;

  assign wr_ctl   = wr && (off == G_CTL);
  assign wr_ist   = wr && (off == G_IST);
  assign hrst_req = wr_ctl && wdata[0];
  assign clr      = wr_ist ? wdata[NPORTS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || hrst_req) begin
      ctl_q  <= CTL_RST;
      gist_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_filter(wdata[1:0]);
      gist_q <= (gist_q & ~clr) | pend;
    end
  end

  assign irq = (gist_q != '0) && ctl_q[1];

  always_comb begin
    case (off)
      G_CAP:   rword = cap_word(NPORTS, NSLOTS);
      G_CTL:   rword = ctl_q;
      G_IST:   rword = 32'(gist_q);
      G_IMPL:  rword = impl_word(NPORTS);
      G_VER:   rword = VER_WORD;
      default: rword = '0;
    endcase
  end
endmodule

// File: rtl/hba_regs_port.sv
module hba_regs_port #(
  parameter int NSLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hrst,
  input  logic              wr,
  input  logic [6:0]        off,
  input  logic [31:0]       wdata,
  input  logic [31:0]       evt,
  input  logic [NSLOTS-1:0] ci_clr,
  input  logic [7:0]        tf_err,
  input  logic [7:0]        tf_sts,
  input  logic              present,
  output logic [31:0]       rword,
  output logic              pend,
  output logic [NSLOTS-1:0] ci_q,
  output logic              prst_q
);
  import hba_regs_pkg::*;

  logic [31:0] ist_q, ien_q, cmd_q, sctl_q;
  logic wr_ist, wr_ien, wr_cmd, wr_sctl, wr_ci;
  logic link_fire;

  assign wr_ist  = wr && (off == P_IST);
  assign wr_ien  = wr && (off == P_IEN);
  assign wr_cmd  = wr && (off == P_CMD);
  assign wr_sctl = wr && (off == P_SCTL);
  assign wr_ci   = wr && (off == P_CI);

  // link-reset field falls from 1 to 0
  assign link_fire = wr_sctl && (sctl_q[3:0] == 4'd1) && (wdata[3:0] == 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || hrst) begin
      ist_q  <= '0;
      ien_q  <= '0;
      cmd_q  <= CMD_RST;
      sctl_q <= '0;
      ci_q   <= '0;
      prst_q <= rst_n && hrst;
    end else begin
      prst_q <= link_fire;
      if (wr_ien)  ien_q  <= ien_filter(wdata);
      if (wr_cmd)  cmd_q  <= cmd_filter(wdata);
      if (wr_sctl) sctl_q <= wdata;
      if (link_fire) begin
        ist_q <= '0;
        ci_q  <= '0;
      end else begin
        ist_q <= (ist_q & ~(wr_ist ? wdata : 32'd0)) | evt;
        ci_q  <= (ci_q & ~ci_clr) | (wr_ci ? wdata[NSLOTS-1:0] : '0);
      end
    end
  end

  assign pend = (ist_q & ien_q) != 32'd0;

  always_comb begin
    case (off)
      P_IST:   rword = ist_q;
      P_IEN:   rword = ien_q;
      P_CMD:   rword = cmd_q;
      P_TF:    rword = tf_word(tf_err, tf_sts);
      P_LINK:  rword = link_word(present);
      P_SCTL:  rword = sctl_q;
      P_CI:    rword = 32'(ci_q);
      default: rword = '0;
    endcase
  end
endmodule

// File: rtl/hba_regs.sv
module hba_regs #(
  parameter int NPORTS = 4,
  parameter int NSLOTS = 32,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [NPORTS*32-1:0]     port_evt,
  input  logic [NPORTS*NSLOTS-1:0] ci_clr,
  input  logic [NPORTS*8-1:0]      tf_err,
  input  logic [NPORTS*8-1:0]      tf_sts,
  input  logic [NPORTS-1:0]        dev_present,
  output logic [NPORTS*NSLOTS-1:0] cmd_issue,
  output logic [NPORTS-1:0]        port_rst,
  output logic                     irq
);

  logic              glb_hit, port_hit;
  logic [NPORTS-1:0] port_sel;
  logic [NPORTS-1:0] port_pend;
  logic              hrst_req;
  logic [31:0]       ghc_q;
  logic [NPORTS-1:0] gis_q;
  logic [31:0]       g_rword;
  logic [31:0]       port_rword [NPORTS];
  logic [31:0]       p_rword;
  logic [31:0]       rd_next;
  logic [31:0]       rdata_q;

  hba_regs_decode #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .glb_hit  (glb_hit),
    .port_hit (port_hit),
    .port_sel (port_sel)
  );

  hba_regs_global #(.NPORTS(NPORTS), .NSLOTS(NSLOTS)) u_glb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_en && glb_hit),
    .off      (addr[7:0]),
    .wdata    (wdata),
    .pend     (port_pend),
    .hrst_req (hrst_req),
    .ctl_q    (ghc_q),
    .gist_q   (gis_q),
    .irq      (irq),
    .rword    (g_rword)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    hba_regs_port #(.NSLOTS(NSLOTS)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .hrst    (hrst_req),
      .wr      (wr_en && port_sel[i]),
      .off     (addr[6:0]),
      .wdata   (wdata),
      .evt     (port_evt[i*32 +: 32]),
      .ci_clr  (ci_clr[i*NSLOTS +: NSLOTS]),
      .tf_err  (tf_err[i*8 +: 8]),
      .tf_sts  (tf_sts[i*8 +: 8]),
      .present (dev_present[i]),
      .rword   (port_rword[i]),
      .pend    (port_pend[i]),
      .ci_q    (cmd_issue[i*NSLOTS +: NSLOTS]),
      .prst_q  (port_rst[i])
    );
  end

  always_comb begin
    p_rword = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (port_sel[i]) p_rword = p_rword | port_rword[i];
    end
  end

  assign rd_next = glb_hit ? g_rword : (port_hit ? p_rword : 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/hba_regs_chk.sv
module hba_regs_chk #(
  parameter int NPORTS = 4,
  parameter int NSLOTS = 32,
  parameter int ADDR_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [31:0]              rdata,
  input logic                     irq,
  input logic [31:0]              ghc_q,
  input logic [NPORTS-1:0]        gis_q,
  input logic [NPORTS-1:0]        port_pend,
  input logic [NPORTS-1:0]        port_rst,
  input logic [NPORTS*NSLOTS-1:0] cmd_issue,
  input logic                     hrst_req
);

  // R10
  gis_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_pend != '0 && !hrst_req) |=> ((gis_q & $past(port_pend)) == $past(port_pend)));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ghc_q[1] |-> !irq);

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hrst_req) |-> ((port_rst & $past(port_rst)) == '0));

  // R9
  ci_nogrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ((cmd_issue & ~$past(cmd_issue)) == '0));

  // R1
  misalign_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(addr[1:0]) != 2'b00) |-> (rdata == 32'd0));

endmodule

bind hba_regs hba_regs_chk #(.NPORTS(NPORTS), .NSLOTS(NSLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .irq       (irq),
  .ghc_q     (ghc_q),
  .gis_q     (gis_q),
  .port_pend (port_pend),
  .port_rst  (port_rst),
  .cmd_issue (cmd_issue),
  .hrst_req  (hrst_req)
);

// File: tb/tb_hba_regs.sv
`timescale 1ns/1ps
module tb_hba_regs;
  localparam int NP = 4;
  localparam int NS = 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP*32-1:0] port_evt = '0;
  logic [NP*NS-1:0] ci_clr = '0;
  logic [NP*8-1:0] tf_err, tf_sts;
  logic [NP-1:0] dev_present = 4'b0101;
  logic [NP*NS-1:0] cmd_issue;
  logic [NP-1:0] port_rst;
  logic irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // engine-side task-file bytes: port p reads error 0x10+p, status 0x50+p
  for (genvar p = 0; p < NP; p++) begin : g_tf
    assign tf_err[p*8 +: 8] = 8'(8'h10 + p);
    assign tf_sts[p*8 +: 8] = 8'(8'h50 + p);
  end

  hba_regs #(.NPORTS(NP), .NSLOTS(NS), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .port_evt(port_evt), .ci_clr(ci_clr),
    .tf_err(tf_err), .tf_sts(tf_sts), .dev_present(dev_present),
    .cmd_issue(cmd_issue), .port_rst(port_rst), .irq(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [11:0] a;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [30] = '{
    '{1'b1, 12'h000, 32'h0,        32'h40001F03, 4'd12}, // R12 capabilities
    '{1'b1, 12'h00C, 32'h0,        32'h0000000F, 4'd12}, // R12 implemented
    '{1'b1, 12'h010, 32'h0,        32'h00010000, 4'd12}, // R12 version
    '{1'b1, 12'h004, 32'h0,        32'h80000000, 4'd11}, // R11 reset value
    '{1'b0, 12'h004, 32'hFFFFFFFE, 32'h0,        4'd11},
    '{1'b1, 12'h004, 32'h0,        32'h80000002, 4'd11}, // R11 filter
    '{1'b1, 12'h118, 32'h0,        32'h00000006, 4'd5},  // R5 reset value
    '{1'b0, 12'h114, 32'hFFFFFFFF, 32'h0,        4'd4},
    '{1'b1, 12'h114, 32'h0,        32'hFDC000FF, 4'd4},  // R4
    '{1'b0, 12'h118, 32'h00000011, 32'h0,        4'd5},
    '{1'b1, 12'h118, 32'h0,        32'h0000C011, 4'd5},  // R5 mirror
    '{1'b0, 12'h198, 32'h0000C000, 32'h0,        4'd5},
    '{1'b1, 12'h198, 32'h0,        32'h00000000, 4'd5},  // R5 discard
    '{1'b0, 12'h1B8, 32'h00000005, 32'h0,        4'd9},
    '{1'b0, 12'h1B8, 32'h000000A0, 32'h0,        4'd9},
    '{1'b1, 12'h1B8, 32'h0,        32'h000000A5, 4'd9},  // R9 accumulate
    '{1'b1, 12'h102, 32'h0,        32'h00000000, 4'd1},  // R1 unaligned read
    '{1'b0, 12'h116, 32'h00000000, 32'h0,        4'd1},
    '{1'b1, 12'h114, 32'h0,        32'hFDC000FF, 4'd1},  // R1 unaligned write
    '{1'b1, 12'h300, 32'h0,        32'h00000000, 4'd1},  // R1 past last port
    '{1'b1, 12'h0F0, 32'h0,        32'h00000000, 4'd1},  // R1 global hole
    '{1'b0, 12'h294, 32'hFFFFFFFF, 32'h0,        4'd1},
    '{1'b1, 12'h294, 32'h0,        32'hFDC000FF, 4'd1},  // R1 port 3 window
    '{1'b1, 12'h214, 32'h0,        32'h00000000, 4'd1},  // R1 port 2 untouched
    '{1'b1, 12'h1A0, 32'h0,        32'h00001151, 4'd6},  // R6
    '{1'b0, 12'h1A0, 32'h0000FFFF, 32'h0,        4'd6},
    '{1'b1, 12'h1A0, 32'h0,        32'h00001151, 4'd6},  // R6 write ignored
    '{1'b1, 12'h128, 32'h0,        32'h00000113, 4'd7},  // R7 present
    '{1'b1, 12'h1A8, 32'h0,        32'h00000000, 4'd7},  // R7 absent
    '{1'b1, 12'h228, 32'h0,        32'h00000113, 4'd7}   // R7 present
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
    d = rdata;
  endtask

  task automatic evt(input int p, input logic [31:0] bits);
    @(negedge clk);
    port_evt[p*32 +: 32] = bits;
    @(negedge clk);
    port_evt = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R2 read path idle
    check("R2 rdata after reset", 128'(rdata), 128'h0);
    check("R10 irq after reset", 128'(irq), 128'h0);
    check("R8 port_rst after reset", 128'(port_rst), 128'h0);
    check("R9 cmd_issue after reset", 128'(cmd_issue), 128'h0);

    foreach (TBL[i]) begin
      if (TBL[i].rd) begin
        rd(TBL[i].a, v);
        check($sformatf("R%0d table entry %0d", TBL[i].req, i), 128'(v), 128'(TBL[i].exp));
      end else begin
        wr(TBL[i].a, TBL[i].wd);
      end
    end
    check("R9 cmd_issue port1", 128'(cmd_issue[NS +: NS]), 128'hA5);

    // R9 engine clear removes slot 0 of port 1
    @(negedge clk); ci_clr[NS] = 1'b1;
    @(negedge clk); ci_clr = '0;
    rd(12'h1B8, v); check("R9 engine clear", 128'(v), 128'hA4);

    // R3/R10 event on port 2, whose mask is zero
    evt(2, 32'h1);
    @(negedge clk);
    check("R10 masked port no irq", 128'(irq), 128'h0);
    rd(12'h210, v); check("R3 port2 status set", 128'(v), 128'h1);
    rd(12'h008, v); check("R10 masked port no summary", 128'(v), 128'h0);

    // R10 enabled event on port 0
    evt(0, 32'h1);
    @(negedge clk);
    check("R10 irq raised", 128'(irq), 128'h1);
    rd(12'h110, v); check("R3 port0 status", 128'(v), 128'h1);
    wr(12'h110, 32'h1);
    rd(12'h110, v); check("R3 write-one-to-clear", 128'(v), 128'h0);
    rd(12'h008, v); check("R10 summary sticky", 128'(v), 128'h1);
    wr(12'h008, 32'h1);
    rd(12'h008, v); check("R10 summary cleared", 128'(v), 128'h0);
    check("R10 irq dropped", 128'(irq), 128'h0);

    // R3 set wins over clear in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h110; wdata = 32'h20; port_evt[31:0] = 32'h20;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0; port_evt = '0;
    rd(12'h110, v); check("R3 set wins", 128'(v), 128'h20);
    wr(12'h110, 32'h20);
    wr(12'h008, 32'hF);
    rd(12'h008, v); check("R10 cleared again", 128'(v), 128'h0);

    // R8 link-reset field 1 -> 0 on port 0
    wr(12'h138, 32'hF0);
    evt(0, 32'h4);
    wr(12'h12C, 32'h1);
    check("R8 no pulse on 0->1", 128'(port_rst), 128'h0);
    wr(12'h12C, 32'h0);
    check("R8 pulse", 128'(port_rst), 128'h1);
    @(negedge clk);
    check("R8 pulse one cycle", 128'(port_rst), 128'h0);
    rd(12'h138, v); check("R8 command issue cleared", 128'(v), 128'h0);
    rd(12'h110, v); check("R8 status cleared", 128'(v), 128'h0);
    wr(12'h12C, 32'h0);
    check("R8 no pulse on 0->0", 128'(port_rst), 128'h0);
    wr(12'h12C, 32'h1);
    wr(12'h12C, 32'h3);
    check("R8 no pulse on 1->3", 128'(port_rst), 128'h0);

    // R11 controller reset
    wr(12'h004, 32'h1);
    check("R11 reset pulses all ports", 128'(port_rst), 128'hF);
    rd(12'h004, v); check("R11 control after reset", 128'(v), 128'h80000000);
    rd(12'h114, v); check("R11 mask after reset", 128'(v), 128'h0);
    rd(12'h118, v); check("R11 command after reset", 128'(v), 128'h6);
    rd(12'h1B8, v); check("R11 issue after reset", 128'(v), 128'h0);
    rd(12'h12C, v); check("R11 serial control after reset", 128'(v), 128'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule